// File: doc/BRIEF.md
# Serial Link Frame Engine

This block drives the bit level of a two-wire serial link on which the master supplies the clock. It owns a link clock output, a data output with its own output-enable, and a data input from the slave. On request it sends either a line break or a command frame. After a command frame it releases the data line, waits for the slave's reply, receives it, and checks the reply's CRC.

A caller starts an operation with a one-cycle `start_i` pulse while `busy_o` is low. The pulse carries a break/command select, a link clock half-period in system clocks, up to 60 left-justified command bits with their count, and the number of data bits expected in an acknowledged reply. The engine raises `busy_o` for the whole operation. It ends the operation with a one-cycle `done_o`, and at that point the 2-bit response code, the reply data and the timeout and CRC error flags become valid. These results stay held until the next start. Address formatting, retries and register-level transactions are left to the caller.

Every logical bit is inverted on the wire, so a logical 1 is a low line. Each bit occupies one link clock slot: the clock is low for the first half of the slot and high for the second half. The engine changes its data output at the start of a slot. It samples the slave's data at the end of a slot, after the slave has shifted out on the rising edge.

Top module: `serial_frame_engine`

## Requirements
- R1: Out of reset the link clock is low, the data output enable is low with data output high, and `busy_o` and `done_o` are low.
- R2: A break request drives the enable high, sends one slot with the line high, then holds the line low for 256 slots, and then completes.
- R3: A command request, with the enable high, sends 50 slots of line high, then one start slot with the line low (logical 1), then `cmd_len_i` payload bits taken from `cmd_bits_i[59]` downward, then 4 CRC bits, most significant first. Every bit is inverted on the line.
- R4: The CRC is a 4-bit register that starts at zero. For each bit, feedback is the bit XOR register bit 3; the register then shifts left by one and is XORed with 4'b0111 when the feedback is 1. On transmit it covers the start bit and the payload. On receive it covers the start bit, the code, the body and the received CRC bits.
- R5: After the last CRC slot the enable drops and the engine samples up to 512 slots for a start bit (line low). A start bit found in slot index 511 is accepted. If none of the 512 slots holds one, the engine completes with `err_timeout_o` set and the code and data at zero.
- R6: After the start bit, 4 code bits arrive most significant first. A code of 4'b0000 (acknowledge) is followed by `data_len_i` data bits and 4 CRC bits, and the data is returned right-justified in `rsp_data_o` with code 0.
- R7: Any nonzero 4-bit code is followed by exactly 7 bits. The first 3 of those bits are returned right-justified as data, and `rsp_code_o` is the low 2 bits of the code (1 busy, 2 address error, 3 slave CRC error).
- R8: If the CRC register is not zero after the last received bit, `err_crc_o` is set at completion and `err_timeout_o` stays clear.
- R9: Each link clock slot lasts 2×`div_i` system clocks: low for `div_i`, then high for `div_i`. The link clock is low whenever the engine is idle.
- R10: `busy_o` is high from the cycle after an accepted start until completion. `done_o` is a single-cycle pulse in the cycle `busy_o` falls. A `start_i` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| brk_i | input | 1 | 1 = send break, 0 = send command frame |
| div_i | input | 8 | Link clock half-period in system clocks (0 treated as 1) |
| cmd_bits_i | input | 60 | Command bits, left-justified (bit 59 sent first) |
| cmd_len_i | input | 6 | Number of command bits, 1 to 60 |
| data_len_i | input | 6 | Data bits expected in an acknowledge reply, 0 to 32 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rsp_code_o | output | 2 | Low 2 bits of the received code |
| rsp_data_o | output | 32 | Received data, right-justified |
| err_timeout_o | output | 1 | No start bit within the wait window |
| err_crc_o | output | 1 | Received CRC check failed |
| lclk_o | output | 1 | Link clock |
| sdo_o | output | 1 | Data line output level |
| sdo_en_o | output | 1 | Data line output enable |
| sdi_i | input | 1 | Data line input level |

## Verification
The bench builds the engine with its default parameters: 60-bit command, 32-bit data, 50 preamble slots, 256 break slots and a 512-slot reply window. These defaults let it reach the exact edges of the reply window (511 accepted, 512 timed out), both command-length extremes (1 and 60 bits), and empty and full acknowledged data fields. Most frames run with a half-period of one system clock to keep long windows short. One frame runs with a half-period of three, which exercises the divider's slot shape.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
// Shared types and the CRC step function of the serial link frame engine.
// Assumes a 4-bit CRC with feedback into the low three bits.
package sfe_pkg;
    localparam int CRC_W = 4;
    localparam logic [CRC_W-1:0] CRC_TAPS = 4'b0111;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BRK_HI,
        S_BRK_LO,
        S_PRE,
        S_TX_SOF,
        S_TX_PAY,
        S_TX_CRC,
        S_RX_WAIT,
        S_RX_CODE,
        S_RX_BODY
    } sfe_state_e;

    // One CRC update for one serial bit.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
    endfunction
endpackage

// File: rtl/sfe_crc4.sv
`timescale 1ns/1ps
// Serial CRC accumulator. Clear has priority over update.
// Assumes at most one bit is fed per system clock.
module sfe_crc4 (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     en_i,
    input  logic                     bit_i,
    output logic [sfe_pkg::CRC_W-1:0] crc_o
);
    // Hold, clear or advance the CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) crc_o <= '0;
        else if (en_i)       crc_o <= sfe_pkg::crc_step(crc_o, bit_i);
    end
endmodule

// File: rtl/sfe_slot_clk.sv
`timescale 1ns/1ps
// Link clock generator: while run_i is high, produces slots of div low
// clocks then div high clocks, and flags the last system clock of each slot.
// Assumes div_i is stable while run_i is high; a zero divider acts as one.
module sfe_slot_clk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             lclk_o,
    output logic             tick_o
);
    logic [DIV_W-1:0] hc_q;
    logic [DIV_W-1:0] last;
    logic             half_q;

    assign last   = (div_i == '0) ? '0 : div_i - 1'b1;
    assign tick_o = run_i && half_q && (hc_q >= last);
    assign lclk_o = half_q;

    // Count system clocks within each half slot and toggle the link clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            hc_q   <= '0;
            half_q <= 1'b0;
        end else if (hc_q >= last) begin
            hc_q   <= '0;
            half_q <= ~half_q;
        end else begin
            hc_q <= hc_q + 1'b1;
        end
    end

    // R9
    tick_low_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !lclk_o);
endmodule

// File: rtl/serial_frame_engine.sv
`timescale 1ns/1ps
// Serial link frame engine: sends a break or an inverted, CRC-protected
// command frame on a master-clocked two-wire link, then turns the line
// around and receives the reply whose length depends on its code.
// Assumes start_i is a pulse, cmd_len_i is 1..CMD_MAX, data_len_i is 0..DATA_MAX.
module serial_frame_engine #(
    parameter int DIV_W      = 8,
    parameter int CMD_MAX    = 60,
    parameter int DATA_MAX   = 32,
    parameter int PRE_SLOTS  = 50,
    parameter int BRK_SLOTS  = 256,
    parameter int WAIT_SLOTS = 512,
    localparam int LEN_W     = $clog2(CMD_MAX + 1),
    localparam int DLEN_W    = $clog2(DATA_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                brk_i,
    input  logic [DIV_W-1:0]    div_i,
    input  logic [CMD_MAX-1:0]  cmd_bits_i,
    input  logic [LEN_W-1:0]    cmd_len_i,
    input  logic [DLEN_W-1:0]   data_len_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [1:0]          rsp_code_o,
    output logic [DATA_MAX-1:0] rsp_data_o,
    output logic                err_timeout_o,
    output logic                err_crc_o,
    output logic                lclk_o,
    output logic                sdo_o,
    output logic                sdo_en_o,
    input  logic                sdi_i
);
    import sfe_pkg::*;

    localparam int CRC_N    = CRC_W;
    localparam int BODY_MAX = DATA_MAX + CRC_N;
    localparam int BL_W     = $clog2(BODY_MAX + 1);
    localparam int NACK_LEN = 7;
    localparam int CNT_W    = $clog2(PRE_SLOTS + BRK_SLOTS + WAIT_SLOTS + 1);

    sfe_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CMD_MAX-1:0]  sh_q;
    logic [LEN_W-1:0]    len_q;
    logic [DLEN_W-1:0]   dlen_q;
    logic [DIV_W-1:0]    div_q;
    logic [3:0]          code_q;
    logic [BL_W-1:0]     blen_q;
    logic [BODY_MAX-1:0] body_q;
    logic [CRC_N-1:0]    crc_q;
    logic                tick;
    logic                rx_bit;
    logic                crc_clr;
    logic                crc_en;
    logic                crc_bit;
    logic [3:0]          code_nx;
    logic [BODY_MAX-1:0] body_nx;

    assign busy_o  = (state_q != S_IDLE);
    assign rx_bit  = ~sdi_i;
    assign code_nx = {code_q[2:0], rx_bit};
    assign body_nx = {body_q[BODY_MAX-2:0], rx_bit};

    sfe_slot_clk #(.DIV_W(DIV_W)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .div_i  (div_q),
        .lclk_o (lclk_o),
        .tick_o (tick)
    );

    sfe_crc4 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (crc_clr),
        .en_i  (crc_en),
        .bit_i (crc_bit),
        .crc_o (crc_q)
    );

    // Select which bit, if any, enters the CRC this cycle.
    always_comb begin
        crc_clr = (state_q == S_IDLE && start_i) ||
                  (state_q == S_TX_CRC && tick && cnt_q == CNT_W'(CRC_N));
        crc_en  = 1'b0;
        crc_bit = 1'b0;
        if (tick) begin
            unique case (state_q)
                S_PRE:     if (cnt_q == CNT_W'(PRE_SLOTS - 1)) begin crc_en = 1'b1; crc_bit = 1'b1; end
                S_TX_SOF:  begin crc_en = 1'b1; crc_bit = sh_q[CMD_MAX-1]; end
                S_TX_PAY:  if (cnt_q != CNT_W'(len_q)) begin crc_en = 1'b1; crc_bit = sh_q[CMD_MAX-1]; end
                S_RX_WAIT: if (rx_bit) begin crc_en = 1'b1; crc_bit = 1'b1; end
                S_RX_CODE, S_RX_BODY: begin crc_en = 1'b1; crc_bit = rx_bit; end
                default: ;
            endcase
        end
    end

    // Sequence the operation one link slot at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= S_IDLE;
            cnt_q         <= '0;
            sh_q          <= '0;
            len_q         <= '0;
            dlen_q        <= '0;
            div_q         <= '0;
            code_q        <= '0;
            blen_q        <= '0;
            body_q        <= '0;
            sdo_o         <= 1'b1;
            sdo_en_o      <= 1'b0;
            done_o        <= 1'b0;
            rsp_code_o    <= '0;
            rsp_data_o    <= '0;
            err_timeout_o <= 1'b0;
            err_crc_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    cnt_q         <= '0;
                    div_q         <= div_i;
                    sdo_en_o      <= 1'b1;
                    sdo_o         <= 1'b1;
                    code_q        <= '0;
                    body_q        <= '0;
                    rsp_code_o    <= '0;
                    rsp_data_o    <= '0;
                    err_timeout_o <= 1'b0;
                    err_crc_o     <= 1'b0;
                    sh_q          <= cmd_bits_i;
                    len_q         <= cmd_len_i;
                    dlen_q        <= data_len_i;
                    state_q       <= brk_i ? S_BRK_HI : S_PRE;
                end
                S_BRK_HI: if (tick) begin
                    state_q <= S_BRK_LO;
                    sdo_o   <= 1'b0;
                    cnt_q   <= '0;
                end
                S_BRK_LO: if (tick) begin
                    if (cnt_q == CNT_W'(BRK_SLOTS - 1)) begin
                        state_q  <= S_IDLE;
                        done_o   <= 1'b1;
                        sdo_en_o <= 1'b0;
                        sdo_o    <= 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                S_PRE: if (tick) begin
                    if (cnt_q == CNT_W'(PRE_SLOTS - 1)) begin
                        state_q <= S_TX_SOF;
                        sdo_o   <= 1'b0;
                        cnt_q   <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                S_TX_SOF: if (tick) begin
                    state_q <= S_TX_PAY;
                    sdo_o   <= ~sh_q[CMD_MAX-1];
                    sh_q    <= sh_q << 1;
                    cnt_q   <= CNT_W'(1);
                end
                S_TX_PAY: if (tick) begin
                    if (cnt_q == CNT_W'(len_q)) begin
                        state_q <= S_TX_CRC;
                        sdo_o   <= ~crc_q[CRC_N-1];
                        cnt_q   <= CNT_W'(1);
                    end else begin
                        sdo_o <= ~sh_q[CMD_MAX-1];
                        sh_q  <= sh_q << 1;
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_TX_CRC: if (tick) begin
                    if (cnt_q == CNT_W'(CRC_N)) begin
                        state_q  <= S_RX_WAIT;
                        sdo_en_o <= 1'b0;
                        sdo_o    <= 1'b1;
                        cnt_q    <= '0;
                    end else begin
                        sdo_o <= ~crc_q[2'd3 - cnt_q[1:0]];
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_RX_WAIT: if (tick) begin
                    if (rx_bit) begin
                        state_q <= S_RX_CODE;
                        cnt_q   <= '0;
                    end else if (cnt_q == CNT_W'(WAIT_SLOTS - 1)) begin
                        state_q       <= S_IDLE;
                        done_o        <= 1'b1;
                        err_timeout_o <= 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                S_RX_CODE: if (tick) begin
                    code_q <= code_nx;
                    if (cnt_q == CNT_W'(3)) begin
                        blen_q  <= (code_nx == 4'd0) ? BL_W'(dlen_q) + BL_W'(CRC_N) : BL_W'(NACK_LEN);
                        state_q <= S_RX_BODY;
                        cnt_q   <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                S_RX_BODY: if (tick) begin
                    body_q <= body_nx;
                    if (cnt_q == CNT_W'(blen_q) - 1'b1) begin
                        state_q    <= S_IDLE;
                        done_o     <= 1'b1;
                        rsp_code_o <= code_q[1:0];
                        rsp_data_o <= DATA_MAX'(body_nx >> CRC_N);
                        err_crc_o  <= (crc_step(crc_q, rx_bit) != '0);
                    end else cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R9
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !lclk_o);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_timeout_o && err_crc_o));
    // R3
    data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en_o && !$stable(sdo_o)) |-> !lclk_o);
endmodule

// File: tb/test_serial_frame_engine.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected line levels, a monitor
// pops them at each link clock rising edge; a slave model answers frames.
module test_serial_frame_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        brk_i = 1'b0;
    logic [7:0]  div_i = 8'd1;
    logic [59:0] cmd_bits_i = '0;
    logic [5:0]  cmd_len_i = 6'd1;
    logic [5:0]  data_len_i = '0;
    logic        busy_o, done_o, err_timeout_o, err_crc_o, lclk_o, sdo_o, sdo_en_o;
    logic [1:0]  rsp_code_o;
    logic [31:0] rsp_data_o;
    logic        sdi_i = 1'b1;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int done_cnt = 0;
    int ops = 0;
    logic exp_q[$];

    serial_frame_engine i_serial_frame_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .brk_i(brk_i), .div_i(div_i),
        .cmd_bits_i(cmd_bits_i), .cmd_len_i(cmd_len_i), .data_len_i(data_len_i),
        .busy_o(busy_o), .done_o(done_o), .rsp_code_o(rsp_code_o), .rsp_data_o(rsp_data_o),
        .err_timeout_o(err_timeout_o), .err_crc_o(err_crc_o), .lclk_o(lclk_o),
        .sdo_o(sdo_o), .sdo_en_o(sdo_en_o), .sdi_i(sdi_i)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done_o) done_cnt <= done_cnt + 1;
    end

    function automatic logic [3:0] tb_crc(input logic [3:0] c, input logic b);
        logic f;
        f = c[3] ^ b;
        tb_crc = {c[2:0], 1'b0} ^ {1'b0, f, f, f};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compare each driven line level with the queued expectation.
    always @(posedge lclk_o) begin
        if (sdo_en_o) begin
            if (exp_q.size() == 0) check(1'b0, "R2/R3 extra driven slot", 64'(sdo_o), 64'hx);
            else begin
                logic e;
                e = exp_q.pop_front();
                check(sdo_o === e, "R3 R4 R2 line level", 64'(sdo_o), 64'(e));
            end
        end
    end

    task automatic wait_done();
        @(negedge clk);
        while (!done_o) @(negedge clk);
    endtask

    task automatic run_break();
        exp_q.push_back(1'b1);
        for (int i = 0; i < 256; i++) exp_q.push_back(1'b0);
        @(negedge clk);
        brk_i = 1'b1; start_i = 1'b1; ops++;
        @(negedge clk);
        start_i = 1'b0; brk_i = 1'b0;
        check(busy_o === 1'b1, "R10 busy after start", 64'(busy_o), 64'd1);
        wait_done();
        check(exp_q.size() == 0, "R2 break slot count", 64'(exp_q.size()), 64'd0);
        check({err_timeout_o, err_crc_o, rsp_code_o} === 4'b0, "R2 break results", 64'({err_timeout_o, err_crc_o, rsp_code_o}), 64'd0);
        @(negedge clk);
        check(!lclk_o && !sdo_en_o && !busy_o, "R9 idle after break", 64'({lclk_o, sdo_en_o, busy_o}), 64'd0);
    endtask

    task automatic run_cmd(input logic [59:0] cmd, input int len, input int dlen, input int wait_n,
                           input logic [3:0] code4, input logic [31:0] data, input bit corrupt,
                           input logic [7:0] div);
        logic [3:0] c;
        logic rb[$];
        int k;
        int t1, t2, t3;
        logic [31:0] exp_data;
        // expected line levels
        for (int i = 0; i < 50; i++) exp_q.push_back(1'b1);
        c = tb_crc(4'd0, 1'b1);
        exp_q.push_back(1'b0);
        for (int i = 0; i < len; i++) begin
            c = tb_crc(c, cmd[59-i]);
            exp_q.push_back(~cmd[59-i]);
        end
        for (int i = 3; i >= 0; i--) exp_q.push_back(~c[i]);
        // reply frame in logical bits
        c = tb_crc(4'd0, 1'b1);
        rb.push_back(1'b1);
        for (int i = 3; i >= 0; i--) begin rb.push_back(code4[i]); c = tb_crc(c, code4[i]); end
        if (code4 == 4'd0) begin
            for (int i = dlen - 1; i >= 0; i--) begin rb.push_back(data[i]); c = tb_crc(c, data[i]); end
            exp_data = (dlen == 0) ? 32'd0 : (data & (32'hFFFF_FFFF >> (32 - dlen)));
        end else begin
            for (int i = 2; i >= 0; i--) begin rb.push_back(data[i]); c = tb_crc(c, data[i]); end
            exp_data = {29'd0, data[2:0]};
        end
        if (corrupt) c[1] = ~c[1];
        for (int i = 3; i >= 0; i--) rb.push_back(c[i]);
        // launch
        @(negedge clk);
        cmd_bits_i = cmd; cmd_len_i = 6'(len); data_len_i = 6'(dlen); div_i = div;
        brk_i = 1'b0; start_i = 1'b1; ops++;
        @(negedge clk);
        start_i = 1'b0;
        div_i = 8'd7;
        // slot shape (R9)
        @(posedge lclk_o); #1 t1 = cyc;
        @(negedge lclk_o); #1 t2 = cyc;
        @(posedge lclk_o); #1 t3 = cyc;
        check(t2 - t1 == int'(div), "R9 high half length", 64'(t2 - t1), 64'(div));
        check(t3 - t1 == 2 * int'(div), "R9 slot length", 64'(t3 - t1), 64'(2 * div));
        // start while busy must be ignored (R10)
        repeat (4) @(posedge lclk_o);
        @(negedge clk);
        start_i = 1'b1; brk_i = 1'b1; cmd_bits_i = ~cmd;
        @(negedge clk);
        start_i = 1'b0; brk_i = 1'b0;
        // slave model
        @(negedge sdo_en_o);
        check(exp_q.size() == 0, "R3 command slot count", 64'(exp_q.size()), 64'd0);
        k = 0;
        forever begin
            @(posedge lclk_o or posedge done_o);
            if (done_o) break;
            #1;
            if (k >= wait_n && (k - wait_n) < rb.size()) sdi_i = ~rb[k - wait_n];
            else sdi_i = 1'b1;
            k++;
        end
        sdi_i = 1'b1;
        @(negedge clk);
        check(done_o === 1'b1 && busy_o === 1'b0, "R10 done with busy low", 64'({done_o, busy_o}), 64'b10);
        if (wait_n >= 512) begin
            check(err_timeout_o === 1'b1, "R5 timeout flag", 64'(err_timeout_o), 64'd1);
            check({rsp_code_o, rsp_data_o, err_crc_o} === '0, "R5 timeout results zero", 64'({rsp_code_o, rsp_data_o}), 64'd0);
        end else if (corrupt) begin
            check(err_crc_o === 1'b1 && err_timeout_o === 1'b0, "R8 crc error flag", 64'({err_crc_o, err_timeout_o}), 64'b10);
        end else begin
            check({err_timeout_o, err_crc_o} === 2'b0, "R4 R5 no error", 64'({err_timeout_o, err_crc_o}), 64'd0);
            check(rsp_code_o === code4[1:0], code4 == 0 ? "R6 ack code" : "R7 code", 64'(rsp_code_o), 64'(code4[1:0]));
            check(rsp_data_o === exp_data, code4 == 0 ? "R6 ack data" : "R7 nack data", 64'(rsp_data_o), 64'(exp_data));
        end
        @(negedge clk);
        check(!lclk_o && !done_o, "R9 R10 clock low, done single", 64'({lclk_o, done_o}), 64'd0);
        div_i = 8'd1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!lclk_o && !sdo_en_o && sdo_o && !busy_o && !done_o, "R1 reset state",
              64'({lclk_o, sdo_en_o, sdo_o, busy_o, done_o}), 64'b00100);
        rst_n = 1'b1;
        @(negedge clk);
        run_break();
        run_cmd(60'hA5F_0C31_7E20_99B4, 28, 32, 3, 4'd0, 32'hDEAD_BEEF, 1'b0, 8'd1);
        run_cmd(60'hFFF_0000_1234_ABCD, 60, 0, 0, 4'd0, 32'd0, 1'b0, 8'd1);
        run_cmd(60'h800_0000_0000_0000, 1, 32, 2, 4'd1, 32'd5, 1'b0, 8'd1);
        run_cmd(60'h3C0_0000_0000_0000, 5, 32, 1, 4'd2, 32'd2, 1'b0, 8'd1);
        run_cmd(60'h123_4567_89AB_CDEF, 12, 32, 4, 4'd3, 32'd7, 1'b0, 8'd1);
        run_cmd(60'h5A5_0000_0000_0000, 8, 32, 0, 4'b0100, 32'd6, 1'b0, 8'd1);
        run_cmd(60'h0F0_F0F0_F0F0_F0F0, 20, 5, 1, 4'd0, 32'h15, 1'b0, 8'd1);
        run_cmd(60'hABC_DEF0_1234_5678, 28, 32, 2, 4'd0, 32'h1357_9BDF, 1'b1, 8'd1);
        run_cmd(60'h777_0000_0000_0000, 10, 16, 511, 4'd0, 32'h0000_C3A5, 1'b0, 8'd1);
        run_cmd(60'h777_0000_0000_0000, 10, 16, 512, 4'd0, 32'h0000_C3A5, 1'b0, 8'd1);
        run_cmd(60'h9E1_0000_0000_0000, 16, 8, 2, 4'd0, 32'h0000_00A7, 1'b0, 8'd3);
        repeat (5) @(negedge clk);
        check(done_cnt == ops, "R10 one done per operation", 64'(done_cnt), 64'(ops));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule